// File: doc/BRIEF.md
# CIS Line-Scan Timing Generator

This block produces the digital control waveforms for a scanning module made of contact image sensor chips chained in series. From a fast system clock it derives a pixel clock whose period and duty are set from configuration. Once per line it issues a start pulse that enters the first chip's shift register. It also drives the video-line reset switch and emits a one-clock strobe to an external converter, along with the index of the pixel being sampled.

Each line has one start-pulse cycle followed by one pixel-clock cycle per pixel. The block watches the end-of-scan return from the last chip. If that return arrives too early, or fails to arrive, the block raises a sticky error. A new line begins only when three conditions hold: a request is pending, the previous line is finished, and the configured minimum line period has elapsed. The interval between start pulses is the integration time of the sensors.

Top module: `cis_line_timer`

## Requirements
- R1: The pixel clock period P in system clocks equals `cfg_period`, raised to MIN_PERIOD (default 16) when smaller. New configuration takes effect at the next pixel-clock period boundary.
- R2: Each period starts with `cp_o` high. The high time is P/2 (floor) when P ≤ FAST_LIMIT (default 20) and P/4 (floor) otherwise.
- R3: `slow_warn_o` is 1 exactly when P exceeds SLOW_LIMIT (default 200).
- R4: `rst_sw_o` equals `cp_o` in every system clock.
- R5: `sp_o` rises one system clock after a pixel-clock rising edge and falls at the next rising edge. Exactly one falling edge of `cp_o` occurs while it is high.
- R6: `adc_stb_o` is one system clock wide. It fires S = min(P − H + `cfg_amp_dly`, P − 1) system clocks after the pixel-clock rising edge, where H is the high time.
- R7: The line holds NP = chips × 192 pixels, with `cfg_chips` clamped to 1..MAX_CHIPS (0 acts as 1). Strobes occur in pixel-clock cycles 1..NP after the start-pulse cycle (cycle 0), and `pix_idx_o` runs 0..NP−1 in ascending order with them.
- R8: A rising edge on `eos_in` in cycle NP or later is accepted. The line then ends at the close of the later of that cycle and cycle NP, and `line_done_o` pulses for one system clock.
- R9: If no end-of-scan is accepted by the close of cycle NP+2, `err_timeout_o` is set and the line ends with `line_done_o`.
- R10: A rising edge on `eos_in` before cycle NP sets `err_early_o` and does not end the line.
- R11: A start pulse needs three things: a pending `line_req`, no line in progress, and at least `cfg_line_cycles` pixel-clock cycles since the previous start-pulse cycle began. A request made during a line is held. With no request, no start pulse is issued.
- R12: Both error flags stay set until reset. After reset, `sp_o`, `adc_stb_o`, `line_done_o` and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_period | input | PW | Pixel clock period in system clocks |
| cfg_amp_dly | input | PW | Amplifier delay added to the strobe offset |
| cfg_chips | input | CHW | Number of cascaded chips |
| cfg_line_cycles | input | LPW | Minimum start-to-start interval in pixel clocks |
| line_req | input | 1 | Request for a new line |
| eos_in | input | 1 | End-of-scan return from the last chip |
| cp_o | output | 1 | Pixel clock |
| sp_o | output | 1 | Start pulse |
| rst_sw_o | output | 1 | Video-line reset switch control |
| adc_stb_o | output | 1 | Converter sample strobe |
| pix_idx_o | output | IW | Index of the sampled pixel |
| line_done_o | output | 1 | One-clock pulse at end of line |
| err_timeout_o | output | 1 | Sticky missing end-of-scan error |
| err_early_o | output | 1 | Sticky premature end-of-scan error |
| slow_warn_o | output | 1 | Pixel rate below the recommended floor |

## Verification
The bench counts the pixel-clock falling edges inside the start pulse. A start pulse that spans two periods would load two tokens and show a count of 2. It places the end-of-scan both right after the start and not at all: a design with the wrong acceptance window would end the line early or never flag the timeout, and the line-end time is checked to the exact system clock. It probes the duty switch on both sides of the fast limit, and the strobe offset both with and without saturation, where an off-by-one would move the sample out of its pixel cycle. It checks start-to-start spacing with a long programmed line period and with the back-to-back minimum, where a design that ignored the done condition would overlap lines.

// File: rtl/cis_line_timer.sv
module cis_line_timer #(
  parameter int PW           = 12,
  parameter int MIN_PERIOD   = 16,
  parameter int FAST_LIMIT   = 20,
  parameter int SLOW_LIMIT   = 200,
  parameter int PIX_PER_CHIP = 192,
  parameter int MAX_CHIPS    = 32,
  parameter int LPW          = 16,
  parameter int CHW          = $clog2(MAX_CHIPS + 1),
  parameter int IW           = $clog2(MAX_CHIPS * PIX_PER_CHIP)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [PW-1:0]  cfg_period,
  input  logic [PW-1:0]  cfg_amp_dly,
  input  logic [CHW-1:0] cfg_chips,
  input  logic [LPW-1:0] cfg_line_cycles,
  input  logic           line_req,
  input  logic           eos_in,
  output logic           cp_o,
  output logic           sp_o,
  output logic           rst_sw_o,
  output logic           adc_stb_o,
  output logic [IW-1:0]  pix_idx_o,
  output logic           line_done_o,
  output logic           err_timeout_o,
  output logic           err_early_o,
  output logic           slow_warn_o
);
  localparam int CW = $clog2(MAX_CHIPS * PIX_PER_CHIP + 3);

  logic [PW-1:0]  ph, p_r, h_r, s_r;
  logic [PW-1:0]  p_eff, h_new, s_new;
  logic [PW:0]    s_sum;
  logic [CHW-1:0] chips_c;
  logic [CW-1:0]  np_new, np_r, cnt;
  logic [LPW-1:0] lp_cnt;
  logic           busy, sp_cyc, eos_seen, req_pend, eos_q;
  logic           wrap, eos_rise, eos_hit, eos_early, line_ok;

  assign p_eff = (cfg_period < PW'(MIN_PERIOD)) ? PW'(MIN_PERIOD) : cfg_period;
  assign h_new = (p_eff <= PW'(FAST_LIMIT)) ? (p_eff >> 1) : (p_eff >> 2);
  assign s_sum = {1'b0, p_eff} - {1'b0, h_new} + {1'b0, cfg_amp_dly};
  assign s_new = (s_sum > ({1'b0, p_eff} - (PW+1)'(1))) ? (p_eff - PW'(1)) : s_sum[PW-1:0];
  assign slow_warn_o = (p_eff > PW'(SLOW_LIMIT));

  assign chips_c = (cfg_chips == '0) ? CHW'(1) :
                   (cfg_chips > CHW'(MAX_CHIPS)) ? CHW'(MAX_CHIPS) : cfg_chips;
  assign np_new  = CW'(chips_c) * CW'(PIX_PER_CHIP);

  assign wrap      = (ph == p_r - PW'(1));
  assign eos_rise  = eos_in & ~eos_q;
  assign eos_hit   = busy & eos_rise & (cnt >= np_r);
  assign eos_early = busy & eos_rise & (cnt < np_r);
  assign line_ok   = req_pend & ~busy &
                     (({1'b0, lp_cnt} + (LPW+1)'(1)) >= {1'b0, cfg_line_cycles});

  assign cp_o        = (ph < h_r);
  assign rst_sw_o    = cp_o;
  assign sp_o        = sp_cyc & (ph != '0);
  assign adc_stb_o   = busy & (cnt != '0) & (cnt <= np_r) & (ph == s_r);
  assign pix_idx_o   = adc_stb_o ? IW'(cnt - CW'(1)) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph            <= '0;
      p_r           <= PW'(MIN_PERIOD);
      h_r           <= PW'(MIN_PERIOD / 2);
      s_r           <= PW'(MIN_PERIOD - 1);
      cnt           <= '0;
      np_r          <= CW'(PIX_PER_CHIP);
      lp_cnt        <= '1;
      busy          <= 1'b0;
      sp_cyc        <= 1'b0;
      eos_seen      <= 1'b0;
      req_pend      <= 1'b0;
      eos_q         <= 1'b0;
      line_done_o   <= 1'b0;
      err_timeout_o <= 1'b0;
      err_early_o   <= 1'b0;
    end else begin
      eos_q       <= eos_in;
      line_done_o <= 1'b0;
      if (eos_hit)   eos_seen    <= 1'b1;
      if (eos_early) err_early_o <= 1'b1;
      if (wrap) begin
        ph     <= '0;
        p_r    <= p_eff;
        h_r    <= h_new;
        s_r    <= s_new;
        sp_cyc <= 1'b0;
        if (lp_cnt != '1) lp_cnt <= lp_cnt + LPW'(1);
        if (busy) begin
          if ((cnt >= np_r) && (eos_seen || eos_hit)) begin
            busy        <= 1'b0;
            line_done_o <= 1'b1;
          end else if (cnt >= np_r + CW'(2)) begin
            busy          <= 1'b0;
            line_done_o   <= 1'b1;
            err_timeout_o <= 1'b1;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end else if (line_ok) begin
          busy     <= 1'b1;
          sp_cyc   <= 1'b1;
          cnt      <= '0;
          np_r     <= np_new;
          lp_cnt   <= '0;
          eos_seen <= 1'b0;
          req_pend <= 1'b0;
        end
      end else begin
        ph <= ph + PW'(1);
      end
      if (line_req) req_pend <= 1'b1;
    end
  end

  logic       cp_q;
  logic [1:0] sp_falls;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cp_q     <= 1'b0;
      sp_falls <= '0;
    end else begin
      cp_q <= cp_o;
      if (!sp_o) sp_falls <= '0;
      else if (cp_q && !cp_o && sp_falls != 2'd3) sp_falls <= sp_falls + 2'd1;
    end
  end

  // R5
  sp_single_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_o |-> (sp_falls <= 2'd1));
  // R5
  sp_rise_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sp_o) |-> cp_o);
  // R5
  sp_fall_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sp_o) |-> $rose(cp_o));
  // R7
  stb_outside_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_stb_o |-> (!sp_o && pix_idx_o < IW'(np_r)));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_done_o |=> !line_done_o);
  // R12
  timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_timeout_o) |-> err_timeout_o);
  // R12
  early_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_early_o) |-> err_early_o);
endmodule

// File: tb/cis_line_timer_bench.sv
module cis_line_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cfg_period = 12'd16;
  logic [11:0] cfg_amp_dly = 12'd2;
  logic [5:0]  cfg_chips = 6'd1;
  logic [15:0] cfg_line_cycles = 16'd1;
  logic        line_req = 1'b0;
  logic        eos_in = 1'b0;
  logic        cp_o, sp_o, rst_sw_o, adc_stb_o, line_done_o;
  logic        err_timeout_o, err_early_o, slow_warn_o;
  logic [12:0] pix_idx_o;
  int cyc = 0;
  int total = 0;
  int bad = 0;

  cis_line_timer u_cis_line_timer (
    .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_amp_dly(cfg_amp_dly),
    .cfg_chips(cfg_chips), .cfg_line_cycles(cfg_line_cycles), .line_req(line_req),
    .eos_in(eos_in), .cp_o(cp_o), .sp_o(sp_o), .rst_sw_o(rst_sw_o),
    .adc_stb_o(adc_stb_o), .pix_idx_o(pix_idx_o), .line_done_o(line_done_o),
    .err_timeout_o(err_timeout_o), .err_early_o(err_early_o), .slow_warn_o(slow_warn_o)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string r, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0; line_req = 1'b0; eos_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_req();
    @(negedge clk); line_req = 1'b1;
    @(negedge clk); line_req = 1'b0;
  endtask

  task automatic measure_cp(output int hi, output int per);
    hi = 0; per = 0;
    for (int i = 0; i < 5000 && cp_o; i++) @(negedge clk);
    for (int i = 0; i < 5000 && !cp_o; i++) @(negedge clk);
    for (int i = 0; i < 5000 && cp_o; i++) begin hi++; @(negedge clk); end
    per = hi;
    for (int i = 0; i < 5000 && !cp_o; i++) begin per++; @(negedge clk); end
  endtask

  task automatic settle_cp(output int hi, output int per);
    measure_cp(hi, per);
    measure_cp(hi, per);
  endtask

  // mode 0: end-of-scan after last strobe; 1: none; 2: early pulse plus normal one
  task automatic run_line(input int np, input int mode, input bit req_again,
                          output int t0, output int nst, output int ierr, output int dn,
                          output int falls, output int fst, output int rsbad);
    logic cpp;
    int   eos_left;
    t0 = -1; nst = 0; ierr = 0; dn = -1; falls = 0; fst = -1; rsbad = 0; eos_left = 0;
    for (int i = 0; i < 20000 && t0 < 0; i++) begin
      @(negedge clk);
      if (sp_o) t0 = cyc;
    end
    if (t0 < 0) return;
    cpp = cp_o;
    for (int i = 0; i < 20000 && dn < 0; i++) begin
      @(negedge clk);
      if (rst_sw_o !== cp_o) rsbad++;
      if (sp_o && cpp && !cp_o) falls++;
      cpp = cp_o;
      if (eos_left > 0) begin
        eos_left--;
        if (eos_left == 0) eos_in = 1'b0;
      end
      if (mode == 2 && cyc - t0 == 3) begin eos_in = 1'b1; eos_left = 2; end
      if (adc_stb_o) begin
        if (int'(pix_idx_o) != nst) ierr++;
        if (nst == 0) fst = cyc - t0;
        nst++;
        if (mode != 1 && nst == np) begin eos_in = 1'b1; eos_left = 3; end
      end
      if (line_done_o) dn = cyc - t0;
      if (req_again && cyc - t0 == 5) line_req = 1'b1;
      else if (req_again && cyc - t0 == 6) line_req = 1'b0;
    end
    eos_in = 1'b0;
  endtask

  task automatic t_reset();
    apply_reset();
    chk("R12 sp after reset", int'(sp_o), 0);
    chk("R12 strobe after reset", int'(adc_stb_o), 0);
    chk("R12 done after reset", int'(line_done_o), 0);
    chk("R12 errors after reset", int'(err_timeout_o) + int'(err_early_o), 0);
  endtask

  task automatic t_clock();
    int hi, per;
    apply_reset();
    cfg_period = 12'd16; settle_cp(hi, per);
    chk("R1 period 16", per, 16);   chk("R2 high fast 16", hi, 8);
    cfg_period = 12'd20; settle_cp(hi, per);
    chk("R2 high at fast limit", hi, 10);
    cfg_period = 12'd21; settle_cp(hi, per);
    chk("R1 period 21", per, 21);   chk("R2 high above fast limit", hi, 5);
    cfg_period = 12'd40; settle_cp(hi, per);
    chk("R2 high slow 40", hi, 10);
    cfg_period = 12'd5; settle_cp(hi, per);
    chk("R1 clamp period", per, 16); chk("R2 clamp high", hi, 8);
    cfg_period = 12'd200; @(negedge clk);
    chk("R3 no warn at limit", int'(slow_warn_o), 0);
    cfg_period = 12'd250; @(negedge clk);
    chk("R3 warn above limit", int'(slow_warn_o), 1);
    cfg_period = 12'd16;
  endtask

  task automatic t_line();
    int t0, nst, ierr, dn, falls, fst, rsbad;
    apply_reset();
    cfg_period = 12'd16; cfg_amp_dly = 12'd2; cfg_chips = 6'd1; cfg_line_cycles = 16'd1;
    pulse_req();
    run_line(192, 0, 1'b0, t0, nst, ierr, dn, falls, fst, rsbad);
    chk("R7 strobe count", nst, 192);
    chk("R7 index order", ierr, 0);
    chk("R5 falls in sp", falls, 1);
    chk("R6 first strobe offset", fst, 25);
    chk("R8 done time", dn, 3087);
    chk("R4 switch follows cp", rsbad, 0);
    chk("R8 no errors", int'(err_timeout_o) + int'(err_early_o), 0);
  endtask

  task automatic t_strobe();
    int t0, nst, ierr, dn, falls, fst, rsbad;
    apply_reset();
    cfg_period = 12'd40; cfg_amp_dly = 12'd3;
    repeat (100) @(negedge clk);
    pulse_req();
    run_line(192, 0, 1'b0, t0, nst, ierr, dn, falls, fst, rsbad);
    chk("R6 offset unsaturated", fst, 72);
    chk("R5 falls slow clock", falls, 1);
    cfg_amp_dly = 12'd50;
    pulse_req();
    run_line(192, 0, 1'b0, t0, nst, ierr, dn, falls, fst, rsbad);
    chk("R6 offset saturated", fst, 78);
    chk("R6 one strobe per pixel", nst, 192);
    cfg_period = 12'd16; cfg_amp_dly = 12'd2;
  endtask

  task automatic t_timeout();
    int t0, nst, ierr, dn, falls, fst, rsbad;
    apply_reset();
    pulse_req();
    run_line(192, 1, 1'b0, t0, nst, ierr, dn, falls, fst, rsbad);
    chk("R9 timeout done time", dn, 3119);
    chk("R9 timeout flag", int'(err_timeout_o), 1);
    chk("R9 no early flag", int'(err_early_o), 0);
    repeat (200) @(negedge clk);
    chk("R12 timeout sticky", int'(err_timeout_o), 1);
    apply_reset();
    chk("R12 cleared by reset", int'(err_timeout_o), 0);
  endtask

  task automatic t_early();
    int t0, nst, ierr, dn, falls, fst, rsbad;
    apply_reset();
    pulse_req();
    run_line(192, 2, 1'b0, t0, nst, ierr, dn, falls, fst, rsbad);
    chk("R10 early flag", int'(err_early_o), 1);
    chk("R10 line not cut short", dn, 3087);
    chk("R10 no timeout", int'(err_timeout_o), 0);
  endtask

  task automatic t_chips();
    int t0, nst, ierr, dn, falls, fst, rsbad;
    apply_reset();
    cfg_chips = 6'd2;
    pulse_req();
    run_line(384, 0, 1'b0, t0, nst, ierr, dn, falls, fst, rsbad);
    chk("R7 two chips count", nst, 384);
    chk("R8 two chips done", dn, 6159);
    cfg_chips = 6'd0;
    pulse_req();
    run_line(192, 0, 1'b0, t0, nst, ierr, dn, falls, fst, rsbad);
    chk("R7 zero chips clamp", nst, 192);
    cfg_chips = 6'd1;
  endtask

  task automatic t_period();
    int ta, tb, nst, ierr, dn, falls, fst, rsbad;
    int seen;
    apply_reset();
    cfg_line_cycles = 16'd300;
    pulse_req();
    run_line(192, 0, 1'b1, ta, nst, ierr, dn, falls, fst, rsbad);
    run_line(192, 0, 1'b0, tb, nst, ierr, dn, falls, fst, rsbad);
    chk("R11 long line period", tb - ta, 4800);
    cfg_line_cycles = 16'd1;
    pulse_req();
    run_line(192, 0, 1'b1, ta, nst, ierr, dn, falls, fst, rsbad);
    run_line(192, 0, 1'b0, tb, nst, ierr, dn, falls, fst, rsbad);
    chk("R11 back to back interval", tb - ta, 3104);
    seen = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (sp_o) seen++;
    end
    chk("R11 no sp without request", seen, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_clock();
    t_line();
    t_strobe();
    t_timeout();
    t_early();
    t_chips();
    t_period();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule